// File: doc/BRIEF.md
# MESI snooping cache line controller

This block keeps the coherence state of every line of one private, direct-mapped cache that sits on a shared snooping bus. Each line is in one of four states: Modified (the only copy, memory out of date), Exclusive (the only copy, memory up to date), Shared (other caches may also hold it, memory up to date) or Invalid. A small tag and state array holds a tag and a state for each index. Data storage is outside the block. The block only decides when data has to move and in which direction.

Requests arrive from two sides. The processor side presents reads and writes and holds each one until `cpu_ready`. Hits that need no bus traffic complete at once. Misses and upgrades raise a bus request, and the request completes after the grant. The snoop side presents transactions from other caches: a read, or a read-for-ownership. The block answers each one in the same cycle. It asserts the shared line when it holds the line, says whether it supplies the data, and says whether memory must also take that data. It then demotes or invalidates its own copy.

A snoop always wins over a processor request to the same index. Replacing a dirty line first writes the victim back.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. A snoop to any index gets no response, and there is no bus request.
- R2: A processor read that misses raises a bus request of kind 0 (read) from the next cycle until the grant. At the grant the line fills as Shared if `bus_shared_in` is high and as Exclusive if it is low. `cpu_ready` rises in the cycle after the grant.
- R3: A processor write to an Invalid or Shared line raises a bus request of kind 1 (read-exclusive). At the grant the line becomes Modified, and `cpu_ready` rises in the cycle after the grant.
- R4: A read hit in Modified, Exclusive or Shared, and a write hit in Modified or Exclusive, assert `cpu_ready` in the same cycle with no bus request. A write hit in Exclusive silently makes the line Modified.
- R5: A snooped read (`snp_excl`=0) has these effects. On a Modified line it asserts `snp_supply` and `snp_memwb` and demotes the line to Shared. On an Exclusive line it asserts `snp_supply` only and demotes the line to Shared. On a Shared line it asserts neither, and the line stays Shared.
- R6: A snooped read-exclusive (`snp_excl`=1) invalidates any valid line. It asserts `snp_supply` and `snp_memwb` only when the line was Modified.
- R7: `snp_shared` is high in the same cycle as any snoop that hits a valid line. A snoop whose tag does not match, or that targets an Invalid line, gives no response and changes nothing.
- R8: A snoop to the same index as a pending processor request is applied first. `cpu_ready` stays low that cycle. In a wait state the bus request is withdrawn and the request is evaluated again in the next cycle.
- R9: A miss that replaces a Modified line first raises a bus request of kind 2 (write-back) with the victim's address. After its grant the fill follows. Replacing an Exclusive or Shared line raises no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req_valid | input | 1 | Processor request present, held until ready |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address; low INDEX_W bits are the index |
| cpu_ready | output | 1 | Processor request completes this cycle |
| snp_valid | input | 1 | Snooped bus transaction present |
| snp_excl | input | 1 | 1 = read-exclusive, 0 = read |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache drives the line's data |
| snp_memwb | output | 1 | Memory must also absorb the supplied data |
| bus_req_valid | output | 1 | Bus request raised |
| bus_req_kind | output | 2 | 0 read, 1 read-exclusive, 2 write-back |
| bus_req_addr | output | ADDR_W | Address of the bus request |
| bus_gnt | input | 1 | Bus request granted this cycle |
| bus_shared_in | input | 1 | Another cache holds the line, valid with grant |

## Verification
Snoop responses and hit completions are combinational, so each is due in the same cycle as its stimulus. A bus request appears one register later, in the cycle after the miss. The filled state becomes visible one cycle after the grant, which is when `cpu_ready` follows. The bench drives every input at the falling edge and samples half a nanosecond before the next rising edge. Each row of its vector table therefore states the outputs of exactly the cycle in which its inputs are present. Multi-cycle sequences such as write-back then fill, or a conflict that forces the request to be evaluated again, are laid out as one row per cycle.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        LN_I = 2'b00,
        LN_S = 2'b01,
        LN_E = 2'b10,
        LN_M = 2'b11
    } line_st_t;

    typedef enum logic [1:0] {
        BQ_RD  = 2'd0,
        BQ_RDX = 2'd1,
        BQ_WB  = 2'd2
    } bus_op_t;

    typedef enum logic [1:0] {
        CF_IDLE,
        CF_EVICT,
        CF_FILL
    } ctrl_st_t;

endpackage

// File: rtl/mesi_tag_array.sv
module mesi_tag_array
    import mesi_pkg::*;
#(
    parameter int INDEX_W = 3,
    parameter int TAG_W   = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] a_idx,
    output line_st_t           a_state,
    output logic [TAG_W-1:0]   a_tag,
    input  logic [INDEX_W-1:0] b_idx,
    output line_st_t           b_state,
    output logic [TAG_W-1:0]   b_tag,
    input  logic               cw_en,
    input  logic [INDEX_W-1:0] cw_idx,
    input  line_st_t           cw_state,
    input  logic [TAG_W-1:0]   cw_tag,
    input  logic               sw_en,
    input  logic [INDEX_W-1:0] sw_idx,
    input  line_st_t           sw_state
);

    localparam int LINES = 1 << INDEX_W;

    typedef struct packed {
        logic [LINES-1:0][1:0]       st;
        logic [LINES-1:0][TAG_W-1:0] tag;
    } arr_t;

    arr_t arr_d, arr_q;

    always_comb begin
        arr_d = arr_q;
        if (cw_en) begin
            arr_d.st[cw_idx]  = cw_state;
            arr_d.tag[cw_idx] = cw_tag;
        end
        // snoop port is applied last so it wins on a shared index
        if (sw_en) begin
            arr_d.st[sw_idx] = sw_state;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arr_q <= '0;
        end else begin
            arr_q <= arr_d;
        end
    end

    assign a_state = line_st_t'(arr_q.st[a_idx]);
    assign a_tag   = arr_q.tag[a_idx];
    assign b_state = line_st_t'(arr_q.st[b_idx]);
    assign b_tag   = arr_q.tag[b_idx];

    // R6 / R5: a snoop-side update is what the line holds one cycle later
    a_r6_snoop_update_lands: assert property (@(posedge clk) disable iff (!rst_n)
        sw_en |=> arr_q.st[$past(sw_idx)] == $past(sw_state));

endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
    import mesi_pkg::*;
#(
    parameter int TAG_W = 13
) (
    input  logic             snp_valid,
    input  logic             snp_excl,
    input  logic [TAG_W-1:0] snp_tag,
    input  line_st_t         line_state,
    input  logic [TAG_W-1:0] line_tag,
    output logic             shared_o,
    output logic             supply_o,
    output logic             memwb_o,
    output logic             wr_en,
    output line_st_t         wr_state
);

    logic hit;

    always_comb begin
        hit      = snp_valid && (line_state != LN_I) && (line_tag == snp_tag);
        shared_o = hit;
        supply_o = 1'b0;
        memwb_o  = 1'b0;
        wr_en    = hit;
        wr_state = snp_excl ? LN_I : LN_S;
        if (hit) begin
            unique case (line_state)
                LN_M: begin
                    supply_o = 1'b1;
                    memwb_o  = 1'b1;
                end
                LN_E: begin
                    supply_o = !snp_excl;
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/mesi_cpu_ctrl.sv
module mesi_cpu_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int INDEX_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  line_st_t                  line_state,
    input  logic [ADDR_W-INDEX_W-1:0] line_tag,
    input  logic                      conflict,
    input  logic                      bus_gnt,
    input  logic                      bus_shared_in,
    output logic                      ready,
    output logic                      breq_valid,
    output logic [1:0]                breq_kind,
    output logic [ADDR_W-1:0]         breq_addr,
    output logic                      wr_en,
    output line_st_t                  wr_state,
    output logic [ADDR_W-INDEX_W-1:0] wr_tag
);

    localparam int TAG_W = ADDR_W - INDEX_W;

    typedef struct packed {
        ctrl_st_t fsm;
        logic     excl;
    } cur_t;

    cur_t cur_d, cur_q;

    logic [TAG_W-1:0]   req_tag;
    logic [INDEX_W-1:0] req_idx;
    logic               hit;

    assign req_tag = req_addr[ADDR_W-1:INDEX_W];
    assign req_idx = req_addr[INDEX_W-1:0];

    always_comb begin
        cur_d      = cur_q;
        ready      = 1'b0;
        wr_en      = 1'b0;
        wr_state   = LN_I;
        wr_tag     = req_tag;
        hit        = (line_state != LN_I) && (line_tag == req_tag);
        breq_valid = (cur_q.fsm != CF_IDLE);
        breq_kind  = (cur_q.fsm == CF_EVICT) ? BQ_WB : (cur_q.excl ? BQ_RDX : BQ_RD);
        breq_addr  = (cur_q.fsm == CF_EVICT) ? {line_tag, req_idx} : req_addr;
        unique case (cur_q.fsm)
            CF_IDLE: begin
                if (req_valid && !conflict) begin
                    if (hit && (!req_write || line_state != LN_S)) begin
                        ready = 1'b1;
                        if (req_write && line_state == LN_E) begin
                            wr_en    = 1'b1;
                            wr_state = LN_M;
                            wr_tag   = line_tag;
                        end
                    end else if (hit) begin
                        cur_d.fsm  = CF_FILL;
                        cur_d.excl = 1'b1;
                    end else if (line_state == LN_M) begin
                        cur_d.fsm = CF_EVICT;
                    end else begin
                        cur_d.fsm  = CF_FILL;
                        cur_d.excl = req_write;
                    end
                end
            end
            CF_EVICT: begin
                if (conflict) begin
                    cur_d.fsm = CF_IDLE;
                end else if (bus_gnt) begin
                    wr_en     = 1'b1;
                    wr_state  = LN_I;
                    wr_tag    = line_tag;
                    cur_d.fsm = CF_IDLE;
                end
            end
            CF_FILL: begin
                if (conflict) begin
                    cur_d.fsm = CF_IDLE;
                end else if (bus_gnt) begin
                    wr_en     = 1'b1;
                    wr_state  = cur_q.excl ? LN_M : (bus_shared_in ? LN_S : LN_E);
                    cur_d.fsm = CF_IDLE;
                end
            end
            default: cur_d.fsm = CF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{fsm: CF_IDLE, excl: 1'b0};
        end else begin
            cur_q <= cur_d;
        end
    end

    // R8: a same-index snoop never lets the processor request complete
    a_r8_conflict_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && conflict) |-> !ready);

    // R9: a write-back is only ever requested for a dirty victim
    a_r9_writeback_of_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (breq_valid && breq_kind == BQ_WB) |-> line_state == LN_M);

    // R2: a grant without conflict closes the bus request by the next cycle
    a_r2_grant_closes_request: assert property (@(posedge clk) disable iff (!rst_n)
        (breq_valid && bus_gnt && !conflict) |=> !breq_valid);

    // R4: completion and bus traffic never coincide
    a_r4_ready_without_bus: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !breq_valid);

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int INDEX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_ready,
    input  logic              snp_valid,
    input  logic              snp_excl,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_supply,
    output logic              snp_memwb,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_kind,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              bus_gnt,
    input  logic              bus_shared_in
);

    localparam int TAG_W = ADDR_W - INDEX_W;

    logic [INDEX_W-1:0] cpu_idx, snp_idx;
    logic [TAG_W-1:0]   snp_tag;
    logic               conflict;

    line_st_t           c_state, s_state, cw_state, sw_state;
    logic [TAG_W-1:0]   c_tag, s_tag, cw_tag;
    logic               cw_en, sw_en;

    assign cpu_idx  = cpu_req_addr[INDEX_W-1:0];
    assign snp_idx  = snp_addr[INDEX_W-1:0];
    assign snp_tag  = snp_addr[ADDR_W-1:INDEX_W];
    assign conflict = snp_valid && (snp_idx == cpu_idx);

    mesi_tag_array #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_idx    (cpu_idx),
        .a_state  (c_state),
        .a_tag    (c_tag),
        .b_idx    (snp_idx),
        .b_state  (s_state),
        .b_tag    (s_tag),
        .cw_en    (cw_en),
        .cw_idx   (cpu_idx),
        .cw_state (cw_state),
        .cw_tag   (cw_tag),
        .sw_en    (sw_en),
        .sw_idx   (snp_idx),
        .sw_state (sw_state)
    );

    mesi_snoop_resp #(.TAG_W(TAG_W)) u_snoop (
        .snp_valid  (snp_valid),
        .snp_excl   (snp_excl),
        .snp_tag    (snp_tag),
        .line_state (s_state),
        .line_tag   (s_tag),
        .shared_o   (snp_shared),
        .supply_o   (snp_supply),
        .memwb_o    (snp_memwb),
        .wr_en      (sw_en),
        .wr_state   (sw_state)
    );

    mesi_cpu_ctrl #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W)) u_cpu (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (cpu_req_valid),
        .req_write     (cpu_req_write),
        .req_addr      (cpu_req_addr),
        .line_state    (c_state),
        .line_tag      (c_tag),
        .conflict      (conflict),
        .bus_gnt       (bus_gnt),
        .bus_shared_in (bus_shared_in),
        .ready         (cpu_ready),
        .breq_valid    (bus_req_valid),
        .breq_kind     (bus_req_kind),
        .breq_addr     (bus_req_addr),
        .wr_en         (cw_en),
        .wr_state      (cw_state),
        .wr_tag        (cw_tag)
    );

    // R7: the shared line only answers an actual snoop
    a_r7_shared_only_on_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        snp_shared |-> snp_valid);

endmodule

// File: tb/mesi_line_ctrl_bench.sv
`timescale 1ns/1ps
module mesi_line_ctrl_bench;

    localparam logic [15:0] A = 16'h0011; // index 1, tag 2
    localparam logic [15:0] B = 16'h0019; // index 1, tag 3
    localparam logic [15:0] C = 16'h0022; // index 2, tag 4
    localparam logic [15:0] D = 16'h002A; // index 2, tag 5
    localparam logic [15:0] Z = 16'h0000;

    typedef struct packed {
        logic [3:0]  rq;
        logic        cv, cw;
        logic [15:0] ca;
        logic        sv, sx;
        logic [15:0] sa;
        logic        g, sh;
        logic        er, eb;
        logic [1:0]  ek;
        logic [15:0] ea;
        logic        es, esu, ewb;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t TBL [NV] = '{
        '{4'd2, 1,0,A, 0,0,Z, 0,0, 0,0,2'd0,Z, 0,0,0}, // R2 read miss
        '{4'd2, 1,0,A, 0,0,Z, 0,0, 0,1,2'd0,A, 0,0,0}, // R2 request up
        '{4'd2, 1,0,A, 0,0,Z, 1,0, 0,1,2'd0,A, 0,0,0}, // R2 grant, fills E
        '{4'd2, 1,0,A, 0,0,Z, 0,0, 1,0,2'd0,Z, 0,0,0}, // R2 ready after grant
        '{4'd5, 0,0,Z, 1,0,A, 0,0, 0,0,2'd0,Z, 1,1,0}, // R5 E supplies, to S
        '{4'd5, 0,0,Z, 1,0,A, 0,0, 0,0,2'd0,Z, 1,0,0}, // R5 S stays S
        '{4'd3, 1,1,A, 0,0,Z, 0,0, 0,0,2'd0,Z, 0,0,0}, // R3 write on S
        '{4'd3, 1,1,A, 0,0,Z, 1,0, 0,1,2'd1,A, 0,0,0}, // R3 read-exclusive granted
        '{4'd3, 1,1,A, 0,0,Z, 0,0, 1,0,2'd0,Z, 0,0,0}, // R3 ready, line M
        '{4'd5, 0,0,Z, 1,0,A, 0,0, 0,0,2'd0,Z, 1,1,1}, // R5 M flushes, to S
        '{4'd6, 0,0,Z, 1,1,A, 0,0, 0,0,2'd0,Z, 1,0,0}, // R6 S invalidated
        '{4'd7, 0,0,Z, 1,0,A, 0,0, 0,0,2'd0,Z, 0,0,0}, // R7 invalid, no answer
        '{4'd3, 1,1,C, 0,0,Z, 0,0, 0,0,2'd0,Z, 0,0,0}, // R3 write miss on I
        '{4'd3, 1,1,C, 0,0,Z, 1,0, 0,1,2'd1,C, 0,0,0}, // R3 read-exclusive granted
        '{4'd3, 1,1,C, 0,0,Z, 0,0, 1,0,2'd0,Z, 0,0,0}, // R3 ready
        '{4'd9, 1,0,D, 0,0,Z, 0,0, 0,0,2'd0,Z, 0,0,0}, // R9 miss over dirty line
        '{4'd9, 1,0,D, 0,0,Z, 0,0, 0,1,2'd2,C, 0,0,0}, // R9 write-back of victim
        '{4'd9, 1,0,D, 0,0,Z, 1,0, 0,1,2'd2,C, 0,0,0}, // R9 write-back granted
        '{4'd9, 1,0,D, 0,0,Z, 0,0, 0,0,2'd0,Z, 0,0,0}, // R9 evaluated again
        '{4'd2, 1,0,D, 0,0,Z, 1,1, 0,1,2'd0,D, 0,0,0}, // R2 fill with shared high
        '{4'd2, 1,0,D, 0,0,Z, 0,0, 1,0,2'd0,Z, 0,0,0}, // R2 ready
        '{4'd7, 0,0,Z, 1,0,C, 0,0, 0,0,2'd0,Z, 0,0,0}, // R7 tag mismatch
        '{4'd6, 0,0,Z, 1,1,D, 0,0, 0,0,2'd0,Z, 1,0,0}, // R6 S invalidated
        '{4'd2, 1,0,A, 0,0,Z, 0,0, 0,0,2'd0,Z, 0,0,0}, // R2 read miss
        '{4'd2, 1,0,A, 0,0,Z, 1,0, 0,1,2'd0,A, 0,0,0}, // R2 fill E
        '{4'd4, 1,1,A, 0,0,Z, 0,0, 1,0,2'd0,Z, 0,0,0}, // R4 silent E to M
        '{4'd5, 0,0,Z, 1,0,A, 0,0, 0,0,2'd0,Z, 1,1,1}, // R5 proves line was M
        '{4'd8, 1,0,A, 1,1,A, 0,0, 0,0,2'd0,Z, 1,0,0}, // R8 snoop first, no ready
        '{4'd8, 1,0,A, 0,0,Z, 0,0, 0,0,2'd0,Z, 0,0,0}, // R8 now a miss
        '{4'd2, 1,0,A, 0,0,Z, 1,0, 0,1,2'd0,A, 0,0,0}, // R2 fill E
        '{4'd4, 1,0,A, 0,0,Z, 0,0, 1,0,2'd0,Z, 0,0,0}, // R4 read hit E
        '{4'd9, 1,0,B, 0,0,Z, 0,0, 0,0,2'd0,Z, 0,0,0}, // R9 clean victim
        '{4'd9, 1,0,B, 0,0,Z, 1,0, 0,1,2'd0,B, 0,0,0}, // R9 no write-back, read
        '{4'd7, 0,0,Z, 1,0,A, 0,0, 0,0,2'd0,Z, 0,0,0}, // R7 old tag gone
        '{4'd4, 1,0,B, 0,0,Z, 0,0, 1,0,2'd0,Z, 0,0,0}, // R4 read hit
        '{4'd8, 1,0,B, 1,0,C, 0,0, 1,0,2'd0,Z, 0,0,0}  // R8 other index no stall
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [15:0] cpu_req_addr = '0;
    logic        snp_valid = 1'b0, snp_excl = 1'b0;
    logic [15:0] snp_addr = '0;
    logic        bus_gnt = 1'b0, bus_shared_in = 1'b0;
    logic        cpu_ready, snp_shared, snp_supply, snp_memwb, bus_req_valid;
    logic [1:0]  bus_req_kind;
    logic [15:0] bus_req_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    mesi_line_ctrl u_mesi_line_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_ready(cpu_ready),
        .snp_valid(snp_valid), .snp_excl(snp_excl), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_supply(snp_supply), .snp_memwb(snp_memwb),
        .bus_req_valid(bus_req_valid), .bus_req_kind(bus_req_kind),
        .bus_req_addr(bus_req_addr), .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in)
    );

    task automatic chk(input string what, input int rq, input logic [15:0] act,
                       input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic cv, input logic cw, input logic [15:0] ca,
                         input logic sv, input logic sx, input logic [15:0] sa,
                         input logic g, input logic sh);
        @(negedge clk);
        cpu_req_valid = cv; cpu_req_write = cw; cpu_req_addr = ca;
        snp_valid = sv; snp_excl = sx; snp_addr = sa;
        bus_gnt = g; bus_shared_in = sh;
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: every index is Invalid after reset, nothing on the bus
        for (int i = 0; i < 8; i++) begin
            drive(0, 0, Z, 1, 0, 16'(i), 0, 0);
            chk("snoop shared after reset", 1, {15'd0, snp_shared}, 16'd0);
            chk("bus request after reset", 1, {15'd0, bus_req_valid}, 16'd0);
        end

        // vector table, one row per cycle
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].cv, TBL[i].cw, TBL[i].ca, TBL[i].sv, TBL[i].sx, TBL[i].sa,
                  TBL[i].g, TBL[i].sh);
            chk($sformatf("row %0d cpu_ready", i), int'(TBL[i].rq), {15'd0, cpu_ready}, {15'd0, TBL[i].er});
            chk($sformatf("row %0d bus_req_valid", i), int'(TBL[i].rq), {15'd0, bus_req_valid}, {15'd0, TBL[i].eb});
            if (TBL[i].eb) begin
                chk($sformatf("row %0d bus_req_kind", i), int'(TBL[i].rq), {14'd0, bus_req_kind}, {14'd0, TBL[i].ek});
                chk($sformatf("row %0d bus_req_addr", i), int'(TBL[i].rq), bus_req_addr, TBL[i].ea);
            end
            chk($sformatf("row %0d snp_shared", i), int'(TBL[i].rq), {15'd0, snp_shared}, {15'd0, TBL[i].es});
            chk($sformatf("row %0d snp_supply", i), int'(TBL[i].rq), {15'd0, snp_supply}, {15'd0, TBL[i].esu});
            chk($sformatf("row %0d snp_memwb", i), int'(TBL[i].rq), {15'd0, snp_memwb}, {15'd0, TBL[i].ewb});
        end

        // R1: a reset in mid-run drops the held line B
        drive(0, 0, Z, 0, 0, Z, 0, 0);
        rst_n = 1'b0;
        #1;
        rst_n = 1'b1;
        drive(0, 0, Z, 1, 0, B, 0, 0);
        chk("snoop after second reset", 1, {15'd0, snp_shared}, 16'd0);

        // R8: a conflicting snoop during the wait withdraws the bus request
        drive(1, 0, A, 0, 0, Z, 0, 0);
        chk("miss cycle, no request yet", 8, {15'd0, bus_req_valid}, 16'd0);
        drive(1, 0, A, 1, 0, B, 0, 0);
        chk("request up during conflict", 8, {15'd0, bus_req_valid}, 16'd1);
        drive(1, 0, A, 0, 0, Z, 0, 0);
        chk("request withdrawn after conflict", 8, {15'd0, bus_req_valid}, 16'd0);
        chk("not ready after conflict", 8, {15'd0, cpu_ready}, 16'd0);
        drive(1, 0, A, 0, 0, Z, 1, 1);
        chk("request raised again", 8, {15'd0, bus_req_valid}, 16'd1);
        drive(1, 0, A, 0, 0, Z, 0, 0);
        chk("ready after shared fill", 2, {15'd0, cpu_ready}, 16'd1);
        drive(0, 0, Z, 1, 0, A, 0, 0);
        chk("shared fill gives no supply", 2, {15'd0, snp_supply}, 16'd0);
        chk("shared fill still held", 2, {15'd0, snp_shared}, 16'd1);

        drive(0, 0, Z, 0, 0, Z, 0, 0);
        finish_run();
    end

endmodule